// File: doc/BRIEF.md
# Memory-Bus Operating-Level Transition Sequencer

This block moves a memory-bus clock and voltage domain from one discrete operating level to another. A requester presents a target bus frequency in kHz together with a one-cycle strobe. The sequencer maps that frequency to a level index and works out the direction of the move. It then runs two handshakes in the order that keeps the domain safe. The first is a voltage request to an external regulator, which answers with acknowledge or error. The second is a chain of divider-group writes, and after each write the sequencer polls that group's status bits.

When the bus speeds up, the regulator is stepped first and the dividers follow. When it slows down, the dividers are reprogrammed first and the voltage is lowered last. With two rails, a failed step on the second rail makes the sequencer return the first rail to its former level. A suspend input sends the domain to the fastest level and then blocks new targets until a resume input arrives.

Top module: `bus_dvfs_seq`

## Requirements
- R1: After reset, `cur_lvl` is 0 (the fastest level) and `busy`, `done`, `err`, `disabled`, `volt_req` and `div_we` are all low.
- R2: A request whose frequency maps to the current level gets a single `done` pulse (with `err` low) on the cycle after the strobe. It causes no voltage request and no divider write.
- R3: Levels 0, 1 and 2 correspond to 400000, 267000 and 133000 kHz, and a lower index means a faster bus. On a move to a faster level, every voltage step finishes before the first divider write. On a move to a slower level, every divider group is written and settles before the first voltage request.
- R4: Divider groups are written in a fixed order, and the group code appears on `div_grp`. The base order is 0 (memory controller), 2 (top), 3 (left bus), 4 (right bus). With the extended group set, group 1 (second memory controller) follows group 0 and group 5 (multimedia) follows group 4.
- R5: In every group, divider value bits [3:0] equal 3 plus the target level. In the two side-bus groups, bits [7:4] are 1 at every level.
- R6: After each write the sequencer waits until the masked bits of `div_stat` are all zero, and bits outside the mask are ignored. The masks are 0x11111111 for group 0, 0x00111111 for group 1, 0x00011111 for group 2, 0x11 for groups 3 and 4, and 0x1111 for group 5.
- R7: A request whose frequency matches no level ends on the next cycle with `done` and `err` high. It causes no voltage or divider activity and leaves the level unchanged.
- R8: With two rails, the main rail (`volt_rail`=0) is stepped before the secondary rail (`volt_rail`=1). If the secondary step returns an error, the main rail is requested back to the previous level and the transition ends with `err` high. A main-rail error ends the transition with `err` high at once.
- R9: `cur_lvl` takes the target level on the same cycle as a `done` without `err`. On any error it keeps its previous value.
- R10: If the masked status bits are still set after POLL_LIMIT polled cycles, the transition aborts with `done` and `err`.
- R11: A `suspend` pulse raises `disabled` and runs a full transition to level 0, voltage first and then every divider group, even when the domain is already at level 0. While `disabled` is high, a request is answered on the next cycle with `done`, `err` low and no change. `resume` clears `disabled`.
- R12: When `suspend` and a request arrive in the same idle cycle, the suspend transition wins and the request is dropped without a response. A `suspend` that arrives during a transition starts its own transition right after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle request strobe |
| tgt_freq | input | FREQ_W | Target bus frequency in kHz |
| suspend | input | 1 | Pulse: force fastest level and disable requests |
| resume | input | 1 | Pulse: re-enable requests |
| volt_ack | input | 1 | Regulator acknowledge, one cycle |
| volt_err | input | 1 | Regulator error, one cycle |
| div_stat | input | 32 | Busy status of the divider group just written |
| volt_req | output | 1 | Voltage request held until acknowledge or error |
| volt_rail | output | 1 | Rail of the request: 0 main, 1 secondary |
| volt_lvl | output | LVL_W | Level whose voltage is requested |
| div_we | output | 1 | Divider write strobe |
| div_grp | output | 3 | Code of the group being written |
| div_val | output | 32 | Divider value for that group |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error qualifier of `done` |
| disabled | output | 1 | Requests are blocked |
| cur_lvl | output | LVL_W | Current operating level |

## Verification
Two functions can land on the same cycle: the suspend takeover and the acceptance of an ordinary request. The bench raises `suspend` and `req` in one idle cycle. It then expects exactly one completion, whose event trail is the suspend transition to level 0, with nothing issued for the dropped target. In a second case the bench raises `suspend` a few cycles into a slow-down transition. That transition must finish in full, and the suspend transition must follow it directly. Both completions are compared in order against the scoreboard.

// File: rtl/bus_dvfs_pkg.sv
package bus_dvfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_VMAIN = 3'd1,
    ST_VSEC  = 3'd2,
    ST_VROLL = 3'd3,
    ST_DWR   = 3'd4,
    ST_DWAIT = 3'd5
  } seq_st_e;

  localparam int GRP_W = 3;

  localparam logic [GRP_W-1:0] G_MC0  = 3'd0;
  localparam logic [GRP_W-1:0] G_MC1  = 3'd1;
  localparam logic [GRP_W-1:0] G_TOP  = 3'd2;
  localparam logic [GRP_W-1:0] G_LBUS = 3'd3;
  localparam logic [GRP_W-1:0] G_RBUS = 3'd4;
  localparam logic [GRP_W-1:0] G_MMED = 3'd5;

  // Frequency in kHz of each operating level; index 0 is the fastest.
  function automatic logic [31:0] lvl_freq(input int unsigned lvl);
    case (lvl)
      0:       return 32'd400000;
      1:       return 32'd267000;
      2:       return 32'd133000;
      default: return 32'd100000;
    endcase
  endfunction

  // Group code written at a given step of the chain.
  function automatic logic [GRP_W-1:0] grp_at(input logic [GRP_W-1:0] step,
                                               input bit ext);
    if (ext)          return step;
    if (step == 3'd0) return G_MC0;
    return step + 3'd1;
  endfunction

  // Busy bits that must drain after a write to each group.
  function automatic logic [31:0] grp_mask(input logic [GRP_W-1:0] grp);
    case (grp)
      G_MC0:          return 32'h1111_1111;
      G_MC1:          return 32'h0011_1111;
      G_TOP:          return 32'h0001_1111;
      G_LBUS, G_RBUS: return 32'h0000_0011;
      G_MMED:         return 32'h0000_1111;
      default:        return 32'h0000_0000;
    endcase
  endfunction

  // Ratio of the controller core divider per level.
  function automatic logic [3:0] core_ratio(input int unsigned lvl);
    case (lvl)
      0:       return 4'd1;
      1:       return 4'd2;
      default: return 4'd5;
    endcase
  endfunction

  // Packed divider word for a group at a level; nibble 0 is the main field.
  function automatic logic [31:0] div_value(input logic [GRP_W-1:0] grp,
                                            input int unsigned lvl);
    logic [3:0] main_f;
    logic [3:0] core_f;
    main_f = 4'(3 + lvl);
    core_f = core_ratio(lvl);
    case (grp)
      G_MC0:          return {8'h00, 4'h1, 4'h1, 4'h1, 4'h1, core_f, main_f};
      G_MC1:          return {20'h00000, 4'h1, core_f, main_f};
      G_TOP:          return {16'h0000, 4'h7, 4'h7, 4'h7, main_f};
      G_LBUS, G_RBUS: return {24'h000000, 4'h1, main_f};
      G_MMED:         return {20'h00000, main_f, main_f, main_f};
      default:        return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/bus_dvfs_lvl_match.sv
module bus_dvfs_lvl_match
  import bus_dvfs_pkg::*;
#(
  parameter int NUM_LEVELS = 3,
  parameter int FREQ_W     = 20,
  parameter int LVL_W      = 2
) (
  input  logic [FREQ_W-1:0] freq,
  output logic              hit,
  output logic [LVL_W-1:0]  lvl
);

  logic [NUM_LEVELS-1:0] eq;
  logic [31:0]           freq_ext;

  assign freq_ext = {{(32-FREQ_W){1'b0}}, freq};

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_cmp
    assign eq[g] = (freq_ext == lvl_freq(g));
  end

  assign hit = |eq;

  always_comb begin
    lvl = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (eq[i]) lvl = LVL_W'(i);
    end
  end

endmodule

// File: rtl/bus_dvfs_poll_timer.sv
module bus_dvfs_poll_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = en && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/bus_dvfs_div_path.sv
module bus_dvfs_div_path
  import bus_dvfs_pkg::*;
#(
  parameter int EXT_GROUPS = 0,
  parameter int LVL_W      = 2
) (
  input  logic [GRP_W-1:0] step,
  input  logic [LVL_W-1:0] lvl,
  output logic [GRP_W-1:0] grp,
  output logic [31:0]      val,
  output logic [31:0]      mask,
  output logic             last
);

  localparam int NSTEP = (EXT_GROUPS != 0) ? 6 : 4;

  assign grp  = grp_at(step, EXT_GROUPS != 0);
  assign last = (step == GRP_W'(NSTEP - 1));
  assign val  = div_value(grp, int'(lvl));
  assign mask = grp_mask(grp);

endmodule

// File: rtl/bus_dvfs_seq.sv
module bus_dvfs_seq
  import bus_dvfs_pkg::*;
#(
  parameter int NUM_LEVELS = 3,
  parameter int FREQ_W     = 20,
  parameter int POLL_LIMIT = 64,
  parameter int DUAL_RAIL  = 0,
  parameter int EXT_GROUPS = 0,
  localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [FREQ_W-1:0] tgt_freq,
  input  logic              suspend,
  input  logic              resume,
  input  logic              volt_ack,
  input  logic              volt_err,
  input  logic [31:0]       div_stat,
  output logic              volt_req,
  output logic              volt_rail,
  output logic [LVL_W-1:0]  volt_lvl,
  output logic              div_we,
  output logic [2:0]        div_grp,
  output logic [31:0]       div_val,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              disabled,
  output logic [LVL_W-1:0]  cur_lvl
);

  seq_st_e          st_q, st_d;
  logic [LVL_W-1:0] cur_q, tgt_q;
  logic [GRP_W-1:0] step_q;
  logic             up_q, dis_q, pend_q, done_q, err_q;

  // Named internal events
  logic             hit;
  logic [LVL_W-1:0] hit_lvl;
  logic             req_moves, req_up, quick_done, quick_err;
  logic             take_susp, take_req, volt_phase_ok;
  logic             go_ok, go_fail;
  logic             stat_clear, poll_tmo, last_grp, step_adv;
  logic [31:0]      grp_msk;

  bus_dvfs_lvl_match #(
    .NUM_LEVELS (NUM_LEVELS),
    .FREQ_W     (FREQ_W),
    .LVL_W      (LVL_W)
  ) u_match (
    .freq (tgt_freq),
    .hit  (hit),
    .lvl  (hit_lvl)
  );

  bus_dvfs_div_path #(
    .EXT_GROUPS (EXT_GROUPS),
    .LVL_W      (LVL_W)
  ) u_path (
    .step (step_q),
    .lvl  (tgt_q),
    .grp  (div_grp),
    .val  (div_val),
    .mask (grp_msk),
    .last (last_grp)
  );

  assign stat_clear = ((div_stat & grp_msk) == 32'h0);

  bus_dvfs_poll_timer #(
    .LIMIT (POLL_LIMIT)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (div_we),
    .en      ((st_q == ST_DWAIT) && !stat_clear),
    .expired (poll_tmo)
  );

  assign req_up     = (hit_lvl < cur_q);
  assign req_moves  = !dis_q && hit && (hit_lvl != cur_q);
  assign quick_err  = !dis_q && !hit;

  always_comb begin
    st_d          = st_q;
    take_susp     = 1'b0;
    take_req      = 1'b0;
    quick_done    = 1'b0;
    volt_phase_ok = 1'b0;
    go_ok         = 1'b0;
    go_fail       = 1'b0;
    step_adv      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (suspend || pend_q) begin
          take_susp = 1'b1;
          st_d      = ST_VMAIN;
        end else if (req) begin
          if (req_moves) begin
            take_req = 1'b1;
            st_d     = req_up ? ST_VMAIN : ST_DWR;
          end else begin
            quick_done = 1'b1;
          end
        end
      end
      ST_VMAIN: begin
        if (volt_err)                 go_fail = 1'b1;
        else if (volt_ack) begin
          if (DUAL_RAIL != 0)         st_d = ST_VSEC;
          else                        volt_phase_ok = 1'b1;
        end
      end
      ST_VSEC: begin
        if (volt_err)                 st_d = ST_VROLL;
        else if (volt_ack)            volt_phase_ok = 1'b1;
      end
      ST_VROLL: begin
        if (volt_ack || volt_err)     go_fail = 1'b1;
      end
      ST_DWR: st_d = ST_DWAIT;
      ST_DWAIT: begin
        if (stat_clear) begin
          if (!last_grp) begin
            step_adv = 1'b1;
            st_d     = ST_DWR;
          end else if (up_q) begin
            go_ok = 1'b1;
          end else begin
            st_d = ST_VMAIN;
          end
        end else if (poll_tmo) begin
          go_fail = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (volt_phase_ok) begin
      if (up_q) st_d  = ST_DWR;
      else      go_ok = 1'b1;
    end
    if (go_ok || go_fail) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      tgt_q  <= '0;
      step_q <= '0;
      up_q   <= 1'b0;
      dis_q  <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= go_ok || go_fail || quick_done;
      err_q  <= go_fail || (quick_done && quick_err);

      if (suspend)     dis_q <= 1'b1;
      else if (resume) dis_q <= 1'b0;

      if (suspend && (st_q != ST_IDLE)) pend_q <= 1'b1;
      else if (take_susp)               pend_q <= 1'b0;

      if (take_susp) begin
        tgt_q <= '0;
        up_q  <= 1'b1;
      end else if (take_req) begin
        tgt_q <= hit_lvl;
        up_q  <= req_up;
      end

      if (take_susp || take_req || (volt_phase_ok && up_q)) step_q <= '0;
      else if (step_adv)                                     step_q <= step_q + 3'd1;

      if (go_ok) cur_q <= tgt_q;
    end
  end

  assign volt_req  = (st_q == ST_VMAIN) || (st_q == ST_VSEC) || (st_q == ST_VROLL);
  assign volt_rail = (st_q == ST_VSEC);
  assign volt_lvl  = (st_q == ST_VROLL) ? cur_q : tgt_q;
  assign div_we    = (st_q == ST_DWR);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign disabled  = dis_q;
  assign cur_lvl   = cur_q;

endmodule

// File: rtl/bus_dvfs_seq_chk.sv
module bus_dvfs_seq_chk #(
  parameter int LVL_W      = 2,
  parameter int POLL_LIMIT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             suspend,
  input logic             volt_req,
  input logic             div_we,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             disabled,
  input logic [LVL_W-1:0] cur_lvl
);

  logic        in_wait;
  int unsigned wcnt;

  assign in_wait = busy && !volt_req && !div_we;

  always_ff @(posedge clk) begin
    if (!rst_n)       wcnt <= 0;
    else if (in_wait) wcnt <= wcnt + 1;
    else              wcnt <= 0;
  end

  // R2: a completion is only reported once the sequencer is idle
  a_r2_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3: voltage and divider handshakes never overlap
  a_r3_no_volt_during_div: assert property (@(posedge clk) disable iff (!rst_n)
    volt_req |-> !div_we);

  // R6: every divider write is followed by at least one status-poll cycle
  a_r6_write_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> !div_we);

  // R9: an error completion leaves the level untouched
  a_r9_level_kept_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $stable(cur_lvl));

  // R10: no status poll lasts longer than the limit
  a_r10_poll_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (wcnt < POLL_LIMIT));

  // R11: a request while disabled starts nothing
  a_r11_disabled_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (disabled && !busy && $past(!busy) && req && !suspend) |=> !busy);

  // R12: suspend in an idle cycle always starts a transition and disables
  a_r12_suspend_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && !busy) |=> (busy && disabled));

endmodule

bind bus_dvfs_seq bus_dvfs_seq_chk #(
  .LVL_W      (LVL_W),
  .POLL_LIMIT (POLL_LIMIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .suspend  (suspend),
  .volt_req (volt_req),
  .div_we   (div_we),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .disabled (disabled),
  .cur_lvl  (cur_lvl)
);

// File: tb/bus_dvfs_seq_tb.sv
`timescale 1ns/1ps
module bus_dvfs_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [19:0] tgt_freq = '0;
  logic        suspend = 1'b0;
  logic        resume = 1'b0;
  logic        volt_ack = 1'b0;
  logic        volt_err = 1'b0;
  logic [31:0] div_stat = 32'h2;
  logic        volt_req, volt_rail, div_we, busy, done, err, disabled;
  logic [1:0]  volt_lvl, cur_lvl;
  logic [2:0]  div_grp;
  logic [31:0] div_val;

  always #10 clk = ~clk;

  bus_dvfs_seq #(
    .NUM_LEVELS (3),
    .FREQ_W     (20),
    .POLL_LIMIT (16),
    .DUAL_RAIL  (1),
    .EXT_GROUPS (1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .tgt_freq(tgt_freq),
    .suspend(suspend), .resume(resume), .volt_ack(volt_ack),
    .volt_err(volt_err), .div_stat(div_stat), .volt_req(volt_req),
    .volt_rail(volt_rail), .volt_lvl(volt_lvl), .div_we(div_we),
    .div_grp(div_grp), .div_val(div_val), .busy(busy), .done(done),
    .err(err), .disabled(disabled), .cur_lvl(cur_lvl)
  );

  // Scoreboard and stimulus controls
  int unsigned exp_q[$];
  int drv_checks = 0, drv_fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int act_cnt = 0, done_cnt = 0, cyc = 0;
  bit fail_rail1 = 0;
  int stuck_grp = 7;

  function automatic int unsigned ev(int k, int a, int b);
    return (k << 24) | (a << 16) | b;
  endfunction

  function automatic logic [31:0] tb_mask(int g);
    case (g)
      0: return 32'h1111_1111;
      1: return 32'h0011_1111;
      2: return 32'h0001_1111;
      3, 4: return 32'h0000_0011;
      5: return 32'h0000_1111;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    drv_checks++;
    if (!ok) begin
      drv_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- models and monitor ----------------
  bit          v_busy = 0;
  int          v_cnt = 0;
  int          v_rail = 0;
  int          stat_left = 0;
  logic [31:0] cur_mask = 32'h0;

  task automatic sb_check(input int unsigned got, input string tag);
    int unsigned e;
    mon_checks++;
    if (exp_q.size() == 0) begin
      mon_fails++;
      $display("FAIL %s: actual %08h expected nothing", tag, got);
    end else begin
      e = exp_q.pop_front();
      if (e != got) begin
        mon_fails++;
        $display("FAIL %s: actual %08h expected %08h", tag, got, e);
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mon_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", drv_checks + mon_checks + 1,
               drv_fails + mon_fails);
      $finish;
    end
    // regulator model
    if (volt_ack || volt_err) begin
      volt_ack = 0; volt_err = 0; v_busy = 0;
    end else if (v_busy) begin
      if (v_cnt == 0) begin
        if (fail_rail1 && v_rail == 1) volt_err = 1;
        else                           volt_ack = 1;
      end else v_cnt--;
    end
    if (volt_req && !v_busy) begin
      v_busy = 1; v_cnt = 2; v_rail = int'(volt_rail);
      act_cnt++;
      sb_check(ev(1, int'(volt_rail), int'(volt_lvl)), "R3 R8 voltage step");
    end
    // divider model
    if (div_we) begin
      act_cnt++;
      mon_checks++;
      if (stat_left != 0) begin
        mon_fails++;
        $display("FAIL R6 write before status drained: actual %0d expected %0d", stat_left, 0);
      end
      sb_check(ev(2, int'(div_grp), int'(div_val[3:0])), "R4 R5 divider write");
      if (div_grp == 3'd3 || div_grp == 3'd4) begin
        mon_checks++;
        if (div_val[7:4] != 4'h1) begin
          mon_fails++;
          $display("FAIL R5 side-bus secondary field: actual %0d expected %0d", div_val[7:4], 1);
        end
      end
      cur_mask = tb_mask(int'(div_grp));
      stat_left = (int'(div_grp) == stuck_grp) ? 1000000 : 3;
    end else if (stuck_grp == 7 && stat_left > 1000) stat_left = 0;
    else if (stat_left > 0) stat_left--;
    div_stat = ((stat_left > 0) ? cur_mask : 32'h0) | 32'h2;
    // completion
    if (done) begin
      done_cnt++;
      sb_check(ev(3, int'(err), int'(cur_lvl)), "R9 completion");
    end
  end

  // ---------------- driver helpers ----------------
  task automatic push_divs(input int lvl);
    for (int s = 0; s < 6; s++) exp_q.push_back(ev(2, s, 3 + lvl));
  endtask

  task automatic push_volts(input int lvl);
    exp_q.push_back(ev(1, 0, lvl));
    exp_q.push_back(ev(1, 1, lvl));
  endtask

  task automatic push_trans(input int to, input bit up);
    if (up) begin push_volts(to); push_divs(to); end
    else    begin push_divs(to);  push_volts(to); end
    exp_q.push_back(ev(3, 0, to));
  endtask

  task automatic wait_dones(input int start, input int n);
    int guard = 0;
    while (done_cnt < start + n && guard < 3000) begin
      @(negedge clk); #1; guard++;
    end
    repeat (4) @(negedge clk);
    #1;
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic do_req(input int f, input int n);
    int s = done_cnt;
    @(negedge clk);
    tgt_freq = 20'(f); req = 1;
    @(negedge clk);
    req = 0;
    wait_dones(s, n);
  endtask

  task automatic do_susp();
    int s = done_cnt;
    @(negedge clk); suspend = 1;
    @(negedge clk); suspend = 0;
    wait_dones(s, 1);
  endtask

  task automatic do_resume();
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
    #1;
  endtask

  initial begin
    int a0, d0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(cur_lvl == 2'd0, "R1 cur_lvl after reset", cur_lvl, 0);
    chk(!busy && !done && !err && !disabled, "R1 flags after reset",
        {busy, done, err, disabled}, 0);
    chk(!volt_req && !div_we, "R1 handshakes idle", {volt_req, div_we}, 0);
    @(negedge clk); rst_n = 1;

    // R2: same level
    a0 = act_cnt;
    exp_q.push_back(ev(3, 0, 0));
    do_req(400000, 1);
    chk(act_cnt == a0, "R2 no activity on same level", act_cnt, a0);

    // R3/R4/R5/R6: slow down 0 -> 2, then speed up 2 -> 1
    push_trans(2, 0);
    do_req(133000, 1);
    chk(cur_lvl == 2'd2, "R9 level after slow-down", cur_lvl, 2);
    push_trans(1, 1);
    do_req(267000, 1);
    chk(cur_lvl == 2'd1, "R9 level after speed-up", cur_lvl, 1);

    // R7: unknown frequency
    a0 = act_cnt;
    exp_q.push_back(ev(3, 1, 1));
    do_req(123456, 1);
    chk(act_cnt == a0, "R7 no activity on unknown frequency", act_cnt, a0);
    chk(cur_lvl == 2'd1, "R7 level unchanged", cur_lvl, 1);

    // R8: secondary rail fails, main rail rolled back
    fail_rail1 = 1;
    exp_q.push_back(ev(1, 0, 0));
    exp_q.push_back(ev(1, 1, 0));
    exp_q.push_back(ev(1, 0, 1));
    exp_q.push_back(ev(3, 1, 1));
    do_req(400000, 1);
    fail_rail1 = 0;
    chk(cur_lvl == 2'd1, "R8 R9 level kept after rail failure", cur_lvl, 1);

    // R10: status poll timeout on group 2
    stuck_grp = 2;
    exp_q.push_back(ev(2, 0, 5));
    exp_q.push_back(ev(2, 1, 5));
    exp_q.push_back(ev(2, 2, 5));
    exp_q.push_back(ev(3, 1, 1));
    do_req(133000, 1);
    stuck_grp = 7;
    repeat (2) @(negedge clk);
    chk(cur_lvl == 2'd1, "R10 level kept after timeout", cur_lvl, 1);

    // R11: suspend from level 1
    push_trans(0, 1);
    do_susp();
    chk(disabled == 1'b1, "R11 disabled after suspend", disabled, 1);
    chk(cur_lvl == 2'd0, "R11 fastest level after suspend", cur_lvl, 0);

    // R11: request ignored while disabled
    a0 = act_cnt;
    exp_q.push_back(ev(3, 0, 0));
    do_req(133000, 1);
    chk(act_cnt == a0, "R11 no activity while disabled", act_cnt, a0);
    chk(cur_lvl == 2'd0, "R11 level unchanged while disabled", cur_lvl, 0);

    // R11: suspend at level 0 still runs a full transition
    a0 = act_cnt;
    push_trans(0, 1);
    do_susp();
    chk(act_cnt == a0 + 8, "R11 full transition at level 0", act_cnt, a0 + 8);

    do_resume();
    chk(disabled == 1'b0, "R11 resume clears disabled", disabled, 0);
    push_trans(2, 0);
    do_req(133000, 1);
    chk(cur_lvl == 2'd2, "R11 requests accepted after resume", cur_lvl, 2);

    // R12: suspend and request in the same idle cycle
    d0 = done_cnt;
    push_trans(0, 1);
    @(negedge clk);
    tgt_freq = 20'(267000); req = 1; suspend = 1;
    @(negedge clk);
    req = 0; suspend = 0;
    wait_dones(d0, 1);
    repeat (20) @(negedge clk);
    #1;
    chk(done_cnt == d0 + 1, "R12 dropped request gets no response", done_cnt, d0 + 1);
    chk(cur_lvl == 2'd0, "R12 suspend target reached", cur_lvl, 0);
    do_resume();

    // R12: suspend during a transition is deferred
    d0 = done_cnt;
    push_trans(1, 0);
    push_trans(0, 1);
    @(negedge clk);
    tgt_freq = 20'(267000); req = 1;
    @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);
    suspend = 1;
    @(negedge clk);
    suspend = 0;
    wait_dones(d0, 2);
    chk(done_cnt == d0 + 2, "R12 deferred suspend completes", done_cnt, d0 + 2);
    chk(cur_lvl == 2'd0 && disabled, "R12 level and disabled after deferred suspend",
        {disabled, cur_lvl}, 4);

    $display("[TB] %0d tests run, %0d failed", drv_checks + mon_checks,
             drv_fails + mon_fails);
    $finish;
  end

endmodule